// File: doc/BRIEF.md
# Serial Register Access Port

This block gives a debug host access to a small bank of 32-bit control and status registers through one data register of a boundary-scan style port. The TAP controller is outside the block and supplies three strobes: capture, shift and update. Each scan moves a 40-bit command word through the block. The low 32 bits carry data. The next 7 bits carry a register address. The top bit is the direction flag. When update arrives, the block issues a single-cycle request on a parallel register bus toward the trace buffer core, either as a write or as a read.

Reads are pipelined across scans. The value returned by a read is held inside the block. The next capture loads it into the data field, so it shifts out during the following scan. Address 4 is the trace RAM data window, and every read of it advances the core's RAM read pointer through a pop strobe. To fetch N consecutive RAM words, the host reads address 4 on N scans and then issues one more scan that reads a harmless address, such as 0, to collect the last word without popping an extra entry.

A small state machine controls the sequence. It has three states: `S_IDLE`, `S_LOADED` and `S_SHIFT`.
- The capture transition enters `S_LOADED` from any state.
- The first shift moves `S_LOADED` to `S_SHIFT`.
- The update transition returns `S_LOADED` or `S_SHIFT` to `S_IDLE` and issues the bus request.
- An update seen in `S_IDLE` is not an update transition. It does nothing.

The register map is as follows:

| Address | Register | Access |
|---|---|---|
| 0 | identification | read-only |
| 1 | RAM depth | read-only |
| 2 | RAM width | read-only |
| 3 | status | read-only |
| 4 | RAM data | read, pops the RAM read pointer |
| 5 | RAM read pointer | read/write |
| 6 | RAM write pointer | read/write |
| 7 | trigger counter | read/write |
| 8 | control | read/write |

Top module: `scan_reg_port`

## Requirements
- R1: The scan word is 40 bits. Bits 31:0 are data, bits 38:32 are the address and bit 39 is the direction flag. `tdo` presents bit 0 of the word, and each cycle with `shift_en` high moves `tdi` in at bit 39. Bits therefore enter and leave least significant bit first.
- R2: A direction flag of 1 selects a write and 0 selects a read. After a valid update, `bus_req` is high on the next cycle. In that cycle `bus_we`, `bus_addr` and `bus_wdata` carry the flag, the address and the data field of the shifted word.
- R3: While `bus_req` is high, `bus_sel[n]` is the only select bit high for addresses n = 0..8. A write to addresses 0..3 (read-only) raises no select bit, so it has no effect on the core.
- R4: Addresses 9..127 raise no select bit. A read of any of these addresses leaves zero as the pending result, whatever `bus_rdata` carries.
- R5: A read request stores `bus_rdata` from its request cycle as the pending result. The data field shifted out on the next scan equals this pending result. A write request leaves the pending result unchanged.
- R6: `ram_pop` is high for exactly one cycle for each read request to address 4. It is never high for any other request.
- R7: Capture loads zero into the address and direction fields. Bits 39:32 shifted out of every scan are therefore zero.
- R8: An update while the state machine is in `S_IDLE` produces no bus request, no pop and no change to the pending result.
- R9: After reset, the state is `S_IDLE`, `tdo` is 0, `bus_req` and `ram_pop` are 0, and the pending result is zero.
- R10: Each valid update gives a `bus_req` pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_en | input | 1 | Capture strobe from the TAP controller |
| shift_en | input | 1 | Shift strobe, one bit per cycle |
| update_en | input | 1 | Update strobe from the TAP controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the scan word) |
| bus_req | output | 1 | Single-cycle register bus request |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | 7 | Request address |
| bus_wdata | output | 32 | Write data |
| bus_sel | output | 9 | One-hot register select, gated by access rights |
| bus_rdata | input | 32 | Read data from the core, valid in the request cycle |
| ram_pop | output | 1 | Advance the core's RAM read pointer |

## Verification
A table of scans mixes writes to writable registers, writes to read-only registers, reads of mapped and unmapped addresses, and back-to-back RAM-data reads followed by a parking read of address 0.
- Comparing each scan's returned data with the previous request separates the pipelined return from a same-scan return.
- Comparing each scan's returned data with the previous request also shows that a write keeps the pending value.
- A bench core that drives a nonzero pattern on unmapped reads distinguishes real zeroing from passing `bus_rdata` through.
- A stray update after the final read checks that an update with no capture before it issues no request and no pop.

// File: rtl/scan_reg_pkg.sv
package scan_reg_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 7;
    localparam int NUM_REGS = 9;
    localparam int RAM_ADDR = 4;
    localparam int RO_COUNT = 4;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOADED = 2'd1,
        S_SHIFT  = 2'd2
    } port_state_t;
endpackage

// File: rtl/scan_shreg.sv
module scan_shreg #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7,
    localparam int LEN   = DATA_W + ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              tdi,
    input  logic [DATA_W-1:0] load_data,
    output logic [LEN-1:0]    word,
    output logic              tdo
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (capture_en) begin
            word <= {{(ADDR_W + 1){1'b0}}, load_data};
        end else if (shift_en) begin
            word <= {tdi, word[LEN-1:1]};
        end
    end

    assign tdo = word[0];

    // R7: the command fields are clear right after a capture
    a_r7_capture_clears_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> (word[LEN-1:DATA_W] == '0));
endmodule

// File: rtl/reg_decode.sv
module reg_decode #(
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 9,
    parameter int RAM_ADDR = 4,
    parameter int RO_COUNT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                mapped,
    output logic                pop
);
    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_sel
            localparam bit READ_ONLY = (g < RO_COUNT);
            assign sel[g] = req && (addr == ADDR_W'(g)) && !(we && READ_ONLY);
        end
    endgenerate

    assign mapped = (addr < ADDR_W'(NUM_REGS));
    assign pop    = req && !we && (addr == ADDR_W'(RAM_ADDR));

    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    a_r3_sel_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (sel == '0));
    a_r4_unmapped_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (addr >= ADDR_W'(NUM_REGS))) |-> (sel == '0));
    a_r6_pop_is_ram_read: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (sel[RAM_ADDR] && !we));
endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
    import scan_reg_pkg::*;
#(
    parameter int P_DATA_W   = scan_reg_pkg::DATA_W,
    parameter int P_ADDR_W   = scan_reg_pkg::ADDR_W,
    parameter int P_NUM_REGS = scan_reg_pkg::NUM_REGS,
    parameter int P_RAM_ADDR = scan_reg_pkg::RAM_ADDR,
    parameter int P_RO_COUNT = scan_reg_pkg::RO_COUNT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture_en,
    input  logic                  shift_en,
    input  logic                  update_en,
    input  logic                  tdi,
    output logic                  tdo,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [P_ADDR_W-1:0]   bus_addr,
    output logic [P_DATA_W-1:0]   bus_wdata,
    output logic [P_NUM_REGS-1:0] bus_sel,
    input  logic [P_DATA_W-1:0]   bus_rdata,
    output logic                  ram_pop
);
    localparam int LEN    = P_DATA_W + P_ADDR_W + 1;
    localparam int FLAG_B = LEN - 1;

    port_state_t        st, st_nx;
    logic [LEN-1:0]     word;
    logic [P_DATA_W-1:0] pending;
    logic               take_update;
    logic               mapped;

    scan_shreg #(.DATA_W(P_DATA_W), .ADDR_W(P_ADDR_W)) u_shreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .tdi        (tdi),
        .load_data  (pending),
        .word       (word),
        .tdo        (tdo)
    );

    reg_decode #(
        .ADDR_W   (P_ADDR_W),
        .NUM_REGS (P_NUM_REGS),
        .RAM_ADDR (P_RAM_ADDR),
        .RO_COUNT (P_RO_COUNT)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req),
        .we     (bus_we),
        .addr   (bus_addr),
        .sel    (bus_sel),
        .mapped (mapped),
        .pop    (ram_pop)
    );

    // next state: capture wins, update closes a scan, shift marks data movement
    always_comb begin
        st_nx = st;
        if (capture_en) begin
            st_nx = S_LOADED;
        end else begin
            unique case (st)
                S_IDLE:            st_nx = S_IDLE;
                S_LOADED, S_SHIFT: begin
                    if (update_en)     st_nx = S_IDLE;
                    else if (shift_en) st_nx = S_SHIFT;
                end
                default:           st_nx = S_IDLE;
            endcase
        end
    end

    assign take_update = update_en && !capture_en && (st != S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // bus request and pending read result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            pending   <= '0;
        end else begin
            bus_req <= take_update;
            if (take_update) begin
                bus_we    <= word[FLAG_B];
                bus_addr  <= word[FLAG_B-1:P_DATA_W];
                bus_wdata <= word[P_DATA_W-1:0];
            end
            if (bus_req && !bus_we) begin
                pending <= mapped ? bus_rdata : '0;
            end
        end
    end

    a_r10_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> !bus_req);
    a_r8_idle_update_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (update_en && !capture_en && st == S_IDLE) |=> !bus_req);
    a_r5_write_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |=> $stable(pending));
    a_r4_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr >= P_ADDR_W'(P_NUM_REGS)) |=> (pending == '0));
endmodule

// File: tb/scan_reg_port_tb.sv
`timescale 1ns/100ps
module scan_reg_port_tb;
    localparam logic [31:0] ID_V    = 32'h1D00_0001;
    localparam logic [31:0] DEPTH_V = 32'h0000_0400;
    localparam logic [31:0] WIDTH_V = 32'h0000_0020;
    localparam logic [31:0] STAT_V  = 32'h0000_000A;
    localparam logic [31:0] RAM_B   = 32'hC0DE_0000;
    localparam int NV = 18;

    // {we, addr, wdata, expected data returned by this scan}
    localparam logic [71:0] VEC [0:NV-1] = '{
        {1'b1, 7'd8,   32'h0000_0003, 32'h0},
        {1'b0, 7'd8,   32'h0,         32'h0},
        {1'b0, 7'd0,   32'h0,         32'h0000_0003},
        {1'b1, 7'd0,   32'hFFFF_FFFF, ID_V},
        {1'b0, 7'd9,   32'h0,         ID_V},
        {1'b0, 7'd4,   32'h0,         32'h0},
        {1'b0, 7'd4,   32'h0,         RAM_B},
        {1'b0, 7'd0,   32'h0,         RAM_B + 32'd1},
        {1'b1, 7'd5,   32'h0000_0010, ID_V},
        {1'b0, 7'd5,   32'h0,         ID_V},
        {1'b0, 7'd7,   32'h0,         32'h0000_0010},
        {1'b1, 7'd7,   32'h0000_0100, 32'h0},
        {1'b0, 7'd127, 32'h0,         32'h0},
        {1'b0, 7'd7,   32'h0,         32'h0},
        {1'b0, 7'd3,   32'h0,         32'h0000_0100},
        {1'b0, 7'd2,   32'h0,         STAT_V},
        {1'b0, 7'd1,   32'h0,         WIDTH_V},
        {1'b0, 7'd0,   32'h0,         DEPTH_V}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
    logic tdo, bus_req, bus_we, ram_pop;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [8:0]  bus_sel;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    scan_reg_port u_dut (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .tdi(tdi), .tdo(tdo), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_sel(bus_sel), .bus_rdata(bus_rdata), .ram_pop(ram_pop)
    );

    // bench model of the trace buffer core
    logic [31:0] rw_regs [5:8];
    int rp = 0;
    always_comb begin
        case (bus_addr)
            7'd0: bus_rdata = ID_V;
            7'd1: bus_rdata = DEPTH_V;
            7'd2: bus_rdata = WIDTH_V;
            7'd3: bus_rdata = STAT_V;
            7'd4: bus_rdata = RAM_B + 32'(rp);
            7'd5: bus_rdata = rw_regs[5];
            7'd6: bus_rdata = rw_regs[6];
            7'd7: bus_rdata = rw_regs[7];
            7'd8: bus_rdata = rw_regs[8];
            default: bus_rdata = 32'hDEAD_BEEF;
        endcase
    end
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 5; k <= 8; k++) rw_regs[k] <= 32'h0;
            rp <= 0;
        end else begin
            if (ram_pop) rp <= rp + 1;
            for (int k = 5; k <= 8; k++)
                if (bus_sel[k] && bus_we) rw_regs[k] <= bus_wdata;
        end
    end

    // monitors, sampled away from the active edge
    int req_cycles = 0, req_runs = 0, pops = 0, bad_sel = 0;
    logic prev_req = 1'b0;
    logic [6:0]  last_waddr = '0;
    logic [31:0] last_wdata = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req) begin
                req_cycles++;
                if (prev_req) req_runs++;
                if (bus_we) begin
                    last_waddr = bus_addr;
                    last_wdata = bus_wdata;
                end
                if (bus_addr <= 7'd8 && !(bus_we && bus_addr <= 7'd3)) begin
                    if (bus_sel != (9'd1 << bus_addr)) bad_sel++;
                end else if (bus_sel != '0) bad_sel++;
            end else if (bus_sel != '0) bad_sel++;
            if (ram_pop) begin
                pops++;
                if (!(bus_req && !bus_we && bus_addr == 7'd4)) bad_sel++;
            end
            prev_req = bus_req;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic scan(input logic we, input logic [6:0] addr, input logic [31:0] data,
                        output logic [39:0] got);
        logic [39:0] cmd;
        cmd = {we, addr, data};
        @(negedge clk) capture_en = 1'b1;
        @(negedge clk) capture_en = 1'b0;
        for (int i = 0; i < 40; i++) begin
            shift_en = 1'b1;
            tdi = cmd[i];
            got[i] = tdo;
            @(negedge clk);
        end
        shift_en = 1'b0;
        update_en = 1'b1;
        @(negedge clk) update_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [39:0] got;
        int runs0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 tdo", {31'd0, tdo}, 32'd0);
        check("R9 bus_req", {31'd0, bus_req}, 32'd0);
        check("R9 ram_pop", {31'd0, ram_pop}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            scan(VEC[v][71], VEC[v][70:64], VEC[v][63:32], got);
            check($sformatf("R5 R1 scan %0d data", v), got[31:0], VEC[v][31:0]);
            check($sformatf("R7 scan %0d cmd bits", v), {24'd0, got[39:32]}, 32'd0);
            if (v == 0) begin
                check("R2 write addr", {25'd0, last_waddr}, 32'd8);
                check("R2 write data", last_wdata, 32'h3);
            end
        end
        // R3: read-only write did not land, unmapped got no select
        check("R3 R4 select pattern errors", 32'(bad_sel), 32'd0);
        check("R3 written reg5", rw_regs[5], 32'h10);
        check("R6 pops after table", 32'(pops), 32'd2);
        check("R10 request count", 32'(req_cycles), 32'(NV));
        check("R10 request runs", 32'(req_runs), 32'd0);

        // R8: stray update with no capture
        scan(1'b0, 7'd4, 32'h0, got);
        check("R5 park read returns prior", got[31:0], ID_V);
        runs0 = req_cycles;
        @(negedge clk) update_en = 1'b1;
        @(negedge clk) update_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 no request", 32'(req_cycles - runs0), 32'd0);
        check("R8 no pop", 32'(pops), 32'd3);
        scan(1'b0, 7'd0, 32'h0, got);
        check("R8 R6 pending kept", got[31:0], RAM_B + 32'd2);
        check("R6 pops final", 32'(pops), 32'd3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule